// File: doc/BRIEF.md
# Event-Driven Performance Level Controller

This block sits beside one processing core and picks one of three performance levels for it. Each level is a pairing of supply voltage and clock frequency. The choice follows the fill level of the core's local event queue. A burst of queued events raises the level straight away. A quiet queue brings the level down to the lowest setting, either after a hold period or at once on a timestep boundary. Each core instance decides on its own and has no shared or global control input.

The supply regulator and the clock generator are not part of this block. Each is reached through a request/acknowledge handshake. The controller drives a voltage-select code and a clock-select code, and each code equals the level index. Voltage and clock changes are ordered so that the clock is never faster than the supply allows.

A whole level change must finish within a cycle budget. If an acknowledge is late, the controller raises an error flag and stops issuing requests.

Top module: `perf_level_ctrl`

## Requirements
- R1: Exactly three levels exist, coded 0, 1 and 2 in rising order of voltage and frequency. The voltage/frequency pairs (700 mV/125 MHz, 850 mV/333 MHz, 1000 mV/500 MHz by default) are parameters and must be strictly ascending. `volt_sel` and `clk_sel` carry the level index.
- R2: The target level is 2 when `q_occ` >= THR_HI (default 12), 1 when `q_occ` >= THR_LO (default 4), and 0 otherwise.
- R3: While stable, a target above the current level starts a raise at the next clock edge. After that edge `volt_req` is 1 and `volt_sel` holds the target. No timestep pulse is needed.
- R4: A raise drives the voltage first. `clk_sel` moves to the new level, with `clk_req` high, only in the cycle after `volt_ack` is seen. `volt_req` and `clk_req` are never high together.
- R5: A lowering moves `clk_sel` first, with `clk_req` high. `volt_sel` drops, with `volt_req` high, only in the cycle after `clk_ack` is seen.
- R6: A lowering without a timestep pulse starts only on the HOLD_CYC-th consecutive cycle (default 8) in which the target is below the current level. Any cycle whose target is not below the current level restarts the count.
- R7: A `ts_tick` pulse while the queue is empty and the level is above 0 starts a lowering to level 0 at that edge, with no hold.
- R8: `lvl_stable` is 0 for the whole of a level change. Occupancy changes during the change do not alter the level being set. The target is evaluated again in the first stable cycle.
- R9: If a change is not complete within ACK_LIMIT cycles (default 25, which is 100 ns at 250 MHz) counted from its starting edge, `ack_err` goes to 1 and stays there until reset. `lvl_stable`, `volt_req` and `clk_req` then stay 0.
- R10: After reset both select codes are 0, `lvl_stable` is 1, and both requests and `ack_err` are 0.
- R11: `clk_sel` never exceeds `volt_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| q_occ | input | QW | Current event queue occupancy |
| ts_tick | input | 1 | Timestep boundary pulse |
| volt_ack | input | 1 | Supply regulator acknowledge |
| clk_ack | input | 1 | Clock generator acknowledge |
| volt_sel | output | 2 | Voltage select code (level index) |
| volt_req | output | 1 | Voltage change request |
| clk_sel | output | 2 | Clock select code (level index) |
| clk_req | output | 1 | Clock change request |
| lvl_stable | output | 1 | No level change in progress |
| ack_err | output | 1 | Sticky acknowledge timeout flag |

## Verification
The bench probes occupancy on both sides of each threshold. A comparator that is off by one would settle one level wrong.

The hysteresis count is checked to the exact cycle, including a burst that interrupts the count partway. A design that starts early, or one that fails to restart the count, is caught on the seventh or eighth cycle.

Phase ordering is sampled on every cycle of every change. Switching the clock before the voltage on a raise, or after it on a lowering, breaks the select-code relation.

Other cases cover a burst that arrives in mid-change, which must be held off and then taken up in the first stable cycle. The timestep shortcut is tested with an empty queue and with a non-empty one. The timeout is tested to the exact cycle, and the error state is checked to stay in place afterwards.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_FLOOR = 2'd0;
    localparam lvl_t LVL_MID   = 2'd1;
    localparam lvl_t LVL_TOP   = 2'd2;

    typedef enum logic [2:0] {
        ST_STABLE,
        ST_UP_V,
        ST_UP_C,
        ST_DN_C,
        ST_DN_V,
        ST_FAULT
    } plc_state_t;

    // Checks that a three-entry operating table rises strictly.
    function automatic bit rising3(input int a, input int b, input int c);
        return (a < b) && (b < c);
    endfunction

endpackage

// File: rtl/plc_target.sv
module plc_target
    import plc_pkg::*;
#(
    parameter int QW     = 8,
    parameter int THR_LO = 4,
    parameter int THR_HI = 12
) (
    input  logic [QW-1:0] occ,
    output lvl_t          tgt,
    output logic          empty
);
    localparam logic [QW-1:0] LO_Q = QW'(THR_LO);
    localparam logic [QW-1:0] HI_Q = QW'(THR_HI);

    always_comb begin
        if (occ >= HI_Q)      tgt = LVL_TOP;
        else if (occ >= LO_Q) tgt = LVL_MID;
        else                  tgt = LVL_FLOOR;
        empty = (occ == '0);
    end
endmodule

// File: rtl/plc_hold.sv
module plc_hold #(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic below,
    output logic done
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !below) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    assign done = below && (cnt == HW'(HOLD_CYC - 1));
endmodule

// File: rtl/plc_timer.sv
module plc_timer #(
    parameter int ACK_LIMIT = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(ACK_LIMIT + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == TW'(ACK_LIMIT - 1));
endmodule

// File: rtl/perf_level_ctrl.sv
module perf_level_ctrl
    import plc_pkg::*;
#(
    parameter int QW        = 8,
    parameter int THR_LO    = 4,
    parameter int THR_HI    = 12,
    parameter int HOLD_CYC  = 8,
    parameter int ACK_LIMIT = 25,
    parameter int VOLT_MV0  = 700,
    parameter int VOLT_MV1  = 850,
    parameter int VOLT_MV2  = 1000,
    parameter int FREQ_MHZ0 = 125,
    parameter int FREQ_MHZ1 = 333,
    parameter int FREQ_MHZ2 = 500
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [QW-1:0] q_occ,
    input  logic          ts_tick,
    input  logic          volt_ack,
    input  logic          clk_ack,
    output logic [1:0]    volt_sel,
    output logic          volt_req,
    output logic [1:0]    clk_sel,
    output logic          clk_req,
    output logic          lvl_stable,
    output logic          ack_err
);
    localparam bit TABLE_OK = rising3(VOLT_MV0, VOLT_MV1, VOLT_MV2)
                           && rising3(FREQ_MHZ0, FREQ_MHZ1, FREQ_MHZ2);

    generate
        if (!TABLE_OK) begin : g_bad_table
            $error("operating table must rise strictly in voltage and frequency");
        end
    endgenerate

    plc_state_t state;
    lvl_t       v_lvl, c_lvl, pend;
    lvl_t       tgt;
    logic       q_empty, below, hold_done, tick_idle, waiting, expired, err_q;

    plc_target #(.QW(QW), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_tgt (
        .occ   (q_occ),
        .tgt   (tgt),
        .empty (q_empty)
    );

    assign tick_idle = (state == ST_STABLE) && ts_tick && q_empty && (c_lvl != LVL_FLOOR);
    assign below     = (state == ST_STABLE) && (tgt < c_lvl) && !tick_idle;

    plc_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .below (below),
        .done  (hold_done)
    );

    assign waiting = (state == ST_UP_V) || (state == ST_UP_C)
                  || (state == ST_DN_C) || (state == ST_DN_V);

    plc_timer #(.ACK_LIMIT(ACK_LIMIT)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (waiting),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_STABLE;
            v_lvl <= LVL_FLOOR;
            c_lvl <= LVL_FLOOR;
            pend  <= LVL_FLOOR;
            err_q <= 1'b0;
        end else begin
            case (state)
                ST_STABLE: begin
                    if (tgt > c_lvl) begin
                        state <= ST_UP_V;
                        v_lvl <= tgt;
                        pend  <= tgt;
                    end else if (tick_idle) begin
                        state <= ST_DN_C;
                        c_lvl <= LVL_FLOOR;
                        pend  <= LVL_FLOOR;
                    end else if (hold_done) begin
                        state <= ST_DN_C;
                        c_lvl <= tgt;
                        pend  <= tgt;
                    end
                end
                ST_UP_V: begin
                    if (volt_ack) begin
                        state <= ST_UP_C;
                        c_lvl <= pend;
                    end else if (expired) begin
                        state <= ST_FAULT;
                        err_q <= 1'b1;
                    end
                end
                ST_UP_C: begin
                    if (clk_ack) state <= ST_STABLE;
                    else if (expired) begin
                        state <= ST_FAULT;
                        err_q <= 1'b1;
                    end
                end
                ST_DN_C: begin
                    if (clk_ack) begin
                        state <= ST_DN_V;
                        v_lvl <= pend;
                    end else if (expired) begin
                        state <= ST_FAULT;
                        err_q <= 1'b1;
                    end
                end
                ST_DN_V: begin
                    if (volt_ack) state <= ST_STABLE;
                    else if (expired) begin
                        state <= ST_FAULT;
                        err_q <= 1'b1;
                    end
                end
                default: state <= ST_FAULT;
            endcase
        end
    end

    assign volt_sel   = v_lvl;
    assign clk_sel    = c_lvl;
    assign volt_req   = (state == ST_UP_V) || (state == ST_DN_V);
    assign clk_req    = (state == ST_UP_C) || (state == ST_DN_C);
    assign lvl_stable = (state == ST_STABLE);
    assign ack_err    = err_q;

endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
    parameter int QW     = 8,
    parameter int THR_HI = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [QW-1:0] q_occ,
    input logic          volt_ack,
    input logic [1:0]    volt_sel,
    input logic          volt_req,
    input logic [1:0]    clk_sel,
    input logic          clk_req,
    input logic          lvl_stable,
    input logic          ack_err
);
    // R11
    sel_order_chk: assert property (@(posedge clk) disable iff (rst)
        clk_sel <= volt_sel);

    // R1
    sel_range_chk: assert property (@(posedge clk) disable iff (rst)
        (volt_sel <= 2'd2) && (clk_sel <= 2'd2));

    // R4
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({volt_req, clk_req}));

    // R8
    stable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_stable |-> (!volt_req && !clk_req && volt_sel == clk_sel));

    // R3
    burst_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_stable && q_occ >= QW'(THR_HI) && clk_sel != 2'd2)
            |=> (volt_req && volt_sel == 2'd2));

    // R4
    up_clock_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (volt_req && volt_ack && volt_sel > clk_sel)
            |=> (clk_req && clk_sel == $past(volt_sel)));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ack_err |=> (ack_err && !lvl_stable && !volt_req && !clk_req));

endmodule

bind perf_level_ctrl plc_checker #(.QW(QW), .THR_HI(THR_HI)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .q_occ      (q_occ),
    .volt_ack   (volt_ack),
    .volt_sel   (volt_sel),
    .volt_req   (volt_req),
    .clk_sel    (clk_sel),
    .clk_req    (clk_req),
    .lvl_stable (lvl_stable),
    .ack_err    (ack_err)
);

// File: tb/sim_perf_level_ctrl.sv
module sim_perf_level_ctrl;
    localparam int QW = 8;
    localparam int LO = 4;
    localparam int HI = 12;
    localparam int HOLD = 8;
    localparam int LIMIT = 25;
    localparam int ACK_DLY = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [QW-1:0] q_occ = '0;
    logic          ts_tick = 1'b0;
    logic          volt_ack = 1'b0;
    logic          clk_ack = 1'b0;
    logic [1:0]    volt_sel, clk_sel;
    logic          volt_req, clk_req, lvl_stable, ack_err;

    int  checks = 0;
    int  failures = 0;
    bit  auto_ack = 1'b1;
    bit  done = 1'b0;
    int  vcnt = 0;
    int  ccnt = 0;

    always #2 clk = ~clk;

    perf_level_ctrl #(.QW(QW), .THR_LO(LO), .THR_HI(HI),
                      .HOLD_CYC(HOLD), .ACK_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst(rst), .q_occ(q_occ), .ts_tick(ts_tick),
        .volt_ack(volt_ack), .clk_ack(clk_ack),
        .volt_sel(volt_sel), .volt_req(volt_req),
        .clk_sel(clk_sel), .clk_req(clk_req),
        .lvl_stable(lvl_stable), .ack_err(ack_err)
    );

    // Regulator and clock generator models: acknowledge ACK_DLY cycles after request.
    initial begin
        forever begin
            @(negedge clk);
            if (volt_req) vcnt = vcnt + 1; else vcnt = 0;
            if (clk_req)  ccnt = ccnt + 1; else ccnt = 0;
            volt_ack = auto_ack && (vcnt == ACK_DLY);
            clk_ack  = auto_ack && (ccnt == ACK_DLY);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; q_occ = '0; ts_tick = 1'b0; auto_ack = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Wait for a change to complete, checking select-code order every cycle.
    task automatic wait_stable(input string req);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            chk(clk_sel <= volt_sel, "R11", "clk_sel above volt_sel", clk_sel, volt_sel);
            if (lvl_stable) return;
        end
        chk(1'b0, req, "change never completed", 0, 1);
    endtask

    task automatic settle_at(input int occ, input int lvl, input string req);
        q_occ = QW'(occ);
        @(negedge clk);
        wait_stable(req);
        chk(volt_sel == 2'(lvl) && clk_sel == 2'(lvl), req, "settled level",
            clk_sel, lvl);
    endtask

    task automatic t_reset();
        do_reset();
        chk(volt_sel == 0 && clk_sel == 0, "R10", "select codes after reset", volt_sel, 0);
        chk(lvl_stable == 1, "R10", "lvl_stable after reset", lvl_stable, 1);
        chk(!volt_req && !clk_req && !ack_err, "R10", "requests/err after reset",
            {volt_req, clk_req, ack_err}, 0);
    endtask

    task automatic t_thresholds();
        do_reset();
        q_occ = QW'(LO - 1);
        repeat (HOLD + 2) @(negedge clk);
        chk(lvl_stable && clk_sel == 0, "R2", "below low threshold keeps level 0", clk_sel, 0);
        settle_at(HI - 1, 1, "R2");
        settle_at(HI, 2, "R2");
        do_reset();
        settle_at(LO, 1, "R1");
    endtask

    task automatic t_raise_order();
        bit saw_v;
        do_reset();
        q_occ = QW'(HI);
        @(negedge clk);
        chk(volt_req && volt_sel == 2 && !lvl_stable, "R3", "immediate raise request",
            volt_sel, 2);
        chk(clk_sel == 0 && !clk_req, "R4", "clock held during voltage phase", clk_sel, 0);
        saw_v = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (volt_ack) saw_v = 1'b1;
            @(negedge clk);
            if (clk_req) break;
        end
        chk(saw_v && clk_req && clk_sel == 2, "R4", "clock switches after voltage ack",
            clk_sel, 2);
        wait_stable("R4");
        chk(volt_sel == 2 && clk_sel == 2, "R1", "level 2 codes", volt_sel, 2);
    endtask

    task automatic t_hold_lower();
        do_reset();
        settle_at(HI, 2, "R6");
        q_occ = '0;
        for (int i = 0; i < HOLD - 1; i++) @(negedge clk);
        chk(lvl_stable, "R6", "stable before hold count ends", lvl_stable, 1);
        @(negedge clk);
        chk(!lvl_stable && clk_req && clk_sel == 0 && volt_sel == 2, "R5",
            "clock lowers first", clk_sel, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (volt_req) break;
        end
        chk(volt_req && volt_sel == 0 && clk_sel == 0, "R5",
            "voltage lowers after clock ack", volt_sel, 0);
        wait_stable("R5");
        // interrupted hold count
        settle_at(HI, 2, "R6");
        q_occ = '0;
        repeat (5) @(negedge clk);
        q_occ = QW'(HI);
        @(negedge clk);
        q_occ = '0;
        for (int i = 0; i < HOLD - 1; i++) @(negedge clk);
        chk(lvl_stable && clk_sel == 2, "R6", "count restarted after burst", clk_sel, 2);
        @(negedge clk);
        chk(!lvl_stable && clk_sel == 0, "R6", "lowering after full hold", clk_sel, 0);
        wait_stable("R6");
    endtask

    task automatic t_tick();
        do_reset();
        settle_at(HI, 2, "R7");
        q_occ = QW'(LO);
        ts_tick = 1'b1;
        @(negedge clk);
        ts_tick = 1'b0;
        chk(lvl_stable && clk_sel == 2, "R7", "tick with pending work ignored", clk_sel, 2);
        q_occ = '0;
        ts_tick = 1'b1;
        @(negedge clk);
        ts_tick = 1'b0;
        chk(!lvl_stable && clk_req && clk_sel == 0, "R7", "tick on empty queue lowers now",
            clk_sel, 0);
        wait_stable("R7");
        chk(volt_sel == 0, "R7", "settled at level 0", volt_sel, 0);
    endtask

    task automatic t_busy();
        do_reset();
        q_occ = QW'(LO);
        @(negedge clk);
        chk(volt_req && volt_sel == 1, "R3", "raise toward level 1", volt_sel, 1);
        q_occ = QW'(HI);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (lvl_stable) break;
            chk(volt_sel == 1 && clk_sel <= 1, "R8", "target held during change", volt_sel, 1);
        end
        chk(lvl_stable && clk_sel == 1, "R8", "first stable cycle at level 1", clk_sel, 1);
        @(negedge clk);
        chk(volt_req && volt_sel == 2 && !lvl_stable, "R8", "re-evaluated right away",
            volt_sel, 2);
        wait_stable("R8");
    endtask

    task automatic t_timeout();
        do_reset();
        auto_ack = 1'b0;
        q_occ = QW'(LO);
        @(negedge clk);
        chk(volt_req && !ack_err, "R9", "raise started", volt_req, 1);
        repeat (LIMIT - 1) @(negedge clk);
        chk(!ack_err && volt_req, "R9", "no error inside budget", ack_err, 0);
        @(negedge clk);
        chk(ack_err && !volt_req && !clk_req && !lvl_stable, "R9", "error at budget end",
            ack_err, 1);
        auto_ack = 1'b1;
        q_occ = '0;
        repeat (HOLD + 4) @(negedge clk);
        chk(ack_err && !lvl_stable && !volt_req && !clk_req, "R9", "error state sticks",
            ack_err, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_thresholds();
        t_raise_order();
        t_hold_lower();
        t_tick();
        t_busy();
        t_timeout();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule